// File: doc/BRIEF.md
# Im2col Pixel Coordinate Generator

This block produces the ordered list of spatial pixel positions that one im2col gather request reads from an NHWC image stack stored without padding. A request supplies the following:

- a start position (image index, row, column, first channel);
- a signed 16-bit filter tap offset for rows and for columns;
- lower and upper corner adjustments that shape a per-image access window;
- a row step and a column step;
- the image height and width;
- the number of pixels to produce.

From these the generator emits one pixel per accepted beat. Each beat carries the image index, the row, the column and the channel start. It also flags whether the position lies inside the stored image, and selects whether an outside position is filled with zero or with NaN.

The walk goes column first, then row. When the rows of the window run out, it continues at the window's top-left corner of the next image. A new request is not needed for that. Because the steps are applied by the generator, a convolution stride costs nothing in the consumer. The consumer reads memory only for in-bounds pixels and inserts the fill constant for the rest.

Top module: `im2col_pixel_walker`

## Requirements
- R1: After reset `req_busy`, `req_done` and `pix_valid` are all low.
- R2: The row window is [lo_h+off_h, (dim_h-1)+hi_h+off_h] and the column window is [lo_w+off_w, (dim_w-1)+hi_w+off_w]. Both ends are included.
- R3: A `req_start` seen while idle makes `pix_valid` high in the next cycle. The first pixel is (start_batch, start_h+off_h, start_w+off_w), and `pix_chan` equals start_chan for every pixel of the request.
- R4: After each accepted pixel the column grows by `step_w`. If the new column would pass the column window's upper end, the column returns to the window's lower end and the row grows by `step_h`.
- R5: If that row would pass the row window's upper end, the image index grows by one, and row and column restart at the window's lower ends.
- R6: `pix_inb` is 1 exactly when 0 <= row < dim_h and 0 <= column < dim_w.
- R7: `pix_fill_nan` is 1 exactly when `pix_inb` is 0 and the request was issued with `fill_nan` = 1. Otherwise a padded pixel takes zero.
- R8: Exactly `pix_count` pixels are emitted. In the cycle after the last handshake `req_done` is high for one cycle, and `req_busy` and `pix_valid` are low.
- R9: While `pix_valid` is high and `pix_ready` is low, every pixel output holds its value.
- R10: A `req_start` while busy, together with any change of the request inputs, has no effect on the running request's pixels.
- R11: A request with `pix_count` = 0 emits no pixel and pulses `req_done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe, taken while idle |
| req_busy | output | 1 | A request is being walked |
| req_done | output | 1 | One-cycle pulse after the last pixel |
| start_batch | input | BW | Start image index |
| start_h | input | CW | Start row, signed |
| start_w | input | CW | Start column, signed |
| start_chan | input | CHW | Channel start |
| off_h | input | 16 | Row tap offset, signed |
| off_w | input | 16 | Column tap offset, signed |
| lo_h | input | CW | Lower corner row adjustment, signed |
| lo_w | input | CW | Lower corner column adjustment, signed |
| hi_h | input | CW | Upper corner row adjustment, signed |
| hi_w | input | CW | Upper corner column adjustment, signed |
| step_h | input | SW | Row step |
| step_w | input | SW | Column step |
| dim_h | input | CW | Image height |
| dim_w | input | CW | Image width |
| pix_count | input | NW | Pixels in this request |
| fill_nan | input | 1 | 1 selects NaN fill, 0 zero fill |
| pix_valid | output | 1 | Pixel beat valid |
| pix_ready | input | 1 | Consumer accepts the beat |
| pix_batch | output | BW | Image index of the pixel |
| pix_h | output | CW+2 | Row of the pixel, signed |
| pix_w | output | CW+2 | Column of the pixel, signed |
| pix_chan | output | CHW | Channel start of the pixel |
| pix_inb | output | 1 | Pixel lies inside the stored image |
| pix_fill_nan | output | 1 | Padded pixel takes NaN |

## Verification
A wrong row, column or wrap decision shows up on the coordinate outputs at the first handshake after the faulty state. It then stays wrong for the rest of the request, because each position is built from the previous one. A wrong remaining count shows up as a missing or extra beat and a misplaced `req_done` pulse in the cycle after the intended last handshake. Fault in the hold path appears on the first stalled cycle. The bench compares every beat against an independent walk model, under irregular ready patterns, so any such fault is seen within one cycle of its effect.

// File: rtl/im2col_pixel_walker.sv
module im2col_pixel_walker #(
  parameter int CW  = 16,
  parameter int BW  = 8,
  parameter int CHW = 16,
  parameter int SW  = 4,
  parameter int NW  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_start,
  output logic                 req_busy,
  output logic                 req_done,
  input  logic [BW-1:0]        start_batch,
  input  logic signed [CW-1:0] start_h,
  input  logic signed [CW-1:0] start_w,
  input  logic [CHW-1:0]       start_chan,
  input  logic signed [15:0]   off_h,
  input  logic signed [15:0]   off_w,
  input  logic signed [CW-1:0] lo_h,
  input  logic signed [CW-1:0] lo_w,
  input  logic signed [CW-1:0] hi_h,
  input  logic signed [CW-1:0] hi_w,
  input  logic [SW-1:0]        step_h,
  input  logic [SW-1:0]        step_w,
  input  logic [CW-1:0]        dim_h,
  input  logic [CW-1:0]        dim_w,
  input  logic [NW-1:0]        pix_count,
  input  logic                 fill_nan,
  output logic                 pix_valid,
  input  logic                 pix_ready,
  output logic [BW-1:0]        pix_batch,
  output logic signed [CW+1:0] pix_h,
  output logic signed [CW+1:0] pix_w,
  output logic [CHW-1:0]       pix_chan,
  output logic                 pix_inb,
  output logic                 pix_fill_nan
);
  localparam int IW = CW + 2;
  localparam logic signed [IW-1:0] ONE = IW'(1);

  logic signed [IW-1:0] cur_h, cur_w, wlo_h, whi_h, wlo_w, whi_w, dh_q, dw_q;
  logic [SW-1:0]        sth_q, stw_q;
  logic [BW-1:0]        bat_q;
  logic [CHW-1:0]       chan_q;
  logic                 nan_q, busy, done;
  logic [NW-1:0]        remain;

  wire signed [IW-1:0] x_oh = IW'(off_h);
  wire signed [IW-1:0] x_ow = IW'(off_w);
  wire signed [IW-1:0] x_dh = signed'(IW'(dim_h));
  wire signed [IW-1:0] x_dw = signed'(IW'(dim_w));

  wire signed [IW-1:0] nxt_w  = cur_w + signed'(IW'(stw_q));
  wire signed [IW-1:0] nxt_h  = cur_h + signed'(IW'(sth_q));
  wire                 wrap_w = nxt_w > whi_w;
  wire                 wrap_h = nxt_h > whi_h;

  assign req_busy     = busy;
  assign req_done     = done;
  assign pix_valid    = busy;
  assign pix_batch    = bat_q;
  assign pix_h        = cur_h;
  assign pix_w        = cur_w;
  assign pix_chan     = chan_q;
  assign pix_inb      = (cur_h >= 0) && (cur_h < dh_q) && (cur_w >= 0) && (cur_w < dw_q);
  assign pix_fill_nan = nan_q && !pix_inb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
      cur_h  <= '0;
      cur_w  <= '0;
      wlo_h  <= '0;
      whi_h  <= '0;
      wlo_w  <= '0;
      whi_w  <= '0;
      dh_q   <= '0;
      dw_q   <= '0;
      sth_q  <= '0;
      stw_q  <= '0;
      bat_q  <= '0;
      chan_q <= '0;
      nan_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req_start && !busy) begin
        cur_h  <= IW'(start_h) + x_oh;
        cur_w  <= IW'(start_w) + x_ow;
        wlo_h  <= IW'(lo_h) + x_oh;
        wlo_w  <= IW'(lo_w) + x_ow;
        whi_h  <= x_dh - ONE + IW'(hi_h) + x_oh;
        whi_w  <= x_dw - ONE + IW'(hi_w) + x_ow;
        dh_q   <= x_dh;
        dw_q   <= x_dw;
        sth_q  <= step_h;
        stw_q  <= step_w;
        bat_q  <= start_batch;
        chan_q <= start_chan;
        nan_q  <= fill_nan;
        remain <= pix_count;
        busy   <= (pix_count != '0);
        done   <= (pix_count == '0);
      end else if (busy && pix_ready) begin
        remain <= remain - 1'b1;
        if (remain == NW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        if (!wrap_w) begin
          cur_w <= nxt_w;
        end else begin
          cur_w <= wlo_w;
          if (!wrap_h) begin
            cur_h <= nxt_h;
          end else begin
            cur_h <= wlo_h;
            bat_q <= bat_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/im2col_pixel_walker_chk.sv
module im2col_pixel_walker_chk #(
  parameter int CW  = 16,
  parameter int BW  = 8,
  parameter int CHW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_start,
  input logic                 req_busy,
  input logic                 req_done,
  input logic                 pix_valid,
  input logic                 pix_ready,
  input logic [BW-1:0]        pix_batch,
  input logic signed [CW+1:0] pix_h,
  input logic signed [CW+1:0] pix_w,
  input logic [CHW-1:0]       pix_chan,
  input logic                 pix_inb,
  input logic                 pix_fill_nan
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_h) && $stable(pix_w)
      && $stable(pix_batch) && $stable(pix_chan) && $stable(pix_inb));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  p_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_busy) |-> req_done);

  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_fill_nan |-> !pix_inb);

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> !pix_valid || (pix_batch == $past(pix_batch))
      || (pix_batch == $past(pix_batch) + 1'b1));

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_start && !req_busy |=> req_busy || req_done);

  p_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> !pix_valid || $stable(pix_chan));
endmodule

bind im2col_pixel_walker im2col_pixel_walker_chk #(.CW(CW), .BW(BW), .CHW(CHW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_busy(req_busy),
  .req_done(req_done), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_batch(pix_batch), .pix_h(pix_h), .pix_w(pix_w), .pix_chan(pix_chan),
  .pix_inb(pix_inb), .pix_fill_nan(pix_fill_nan)
);

// File: tb/im2col_pixel_walker_tb_top.sv
module im2col_pixel_walker_tb_top;
  localparam int CW = 16, BW = 8, CHW = 16, SW = 4, NW = 10;
  localparam int NCFG = 6;
  //                               basic pad   shift multi stride one
  localparam int T_B  [NCFG] = '{  0,    0,    0,    0,    2,    3};
  localparam int T_SH [NCFG] = '{  0,    1,   -1,    1,   -1,    2};
  localparam int T_SW [NCFG] = '{  0,    2,   -1,    3,   -1,    1};
  localparam int T_CH [NCFG] = '{  0,   32,    0,    5,   64,   77};
  localparam int T_OH [NCFG] = '{  0,    0,    1,    0,    1,   -2};
  localparam int T_OW [NCFG] = '{  0,    0,    1,    0,    0,    3};
  localparam int T_LH [NCFG] = '{  0,   -1,   -1,    0,   -1,    0};
  localparam int T_LW [NCFG] = '{  0,   -1,   -1,    0,   -1,    0};
  localparam int T_HH [NCFG] = '{  0,   -1,   -1,    0,    0,    0};
  localparam int T_HW [NCFG] = '{  0,   -1,   -1,    0,    0,    0};
  localparam int T_TH [NCFG] = '{  1,    1,    1,    1,    2,    1};
  localparam int T_TW [NCFG] = '{  1,    1,    1,    1,    2,    1};
  localparam int T_DH [NCFG] = '{  4,    4,    4,    4,    5,    4};
  localparam int T_DW [NCFG] = '{  4,    4,    4,    4,    5,    4};
  localparam int T_N  [NCFG] = '{ 16,   16,   16,   16,   20,    1};
  localparam int T_NAN[NCFG] = '{  0,    1,    0,    0,    1,    0};

  logic clk = 1'b0, rst_n = 1'b0, req_start = 1'b0, pix_ready = 1'b0, fill_nan = 1'b0;
  logic req_busy, req_done, pix_valid, pix_inb, pix_fill_nan;
  logic [BW-1:0] start_batch = '0, pix_batch;
  logic signed [CW-1:0] start_h = '0, start_w = '0, lo_h = '0, lo_w = '0, hi_h = '0, hi_w = '0;
  logic [CHW-1:0] start_chan = '0, pix_chan;
  logic signed [15:0] off_h = '0, off_w = '0;
  logic [SW-1:0] step_h = '0, step_w = '0;
  logic [CW-1:0] dim_h = '0, dim_w = '0;
  logic [NW-1:0] pix_count = '0;
  logic signed [CW+1:0] pix_h, pix_w;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  im2col_pixel_walker #(.CW(CW), .BW(BW), .CHW(CHW), .SW(SW), .NW(NW)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int i);
    start_batch = BW'(T_B[i]); start_h = CW'(T_SH[i]); start_w = CW'(T_SW[i]);
    start_chan = CHW'(T_CH[i]); off_h = 16'(T_OH[i]); off_w = 16'(T_OW[i]);
    lo_h = CW'(T_LH[i]); lo_w = CW'(T_LW[i]); hi_h = CW'(T_HH[i]); hi_w = CW'(T_HW[i]);
    step_h = SW'(T_TH[i]); step_w = SW'(T_TW[i]); dim_h = CW'(T_DH[i]); dim_w = CW'(T_DW[i]);
    pix_count = NW'(T_N[i]); fill_nan = T_NAN[i][0];
  endtask

  task automatic run_cfg(input int i);
    int mb, mh, mw, loh, hih, low, hiw, got, cyc, ph, pw;
    bit stalled, einb;
    loh = T_LH[i] + T_OH[i]; hih = T_DH[i] - 1 + T_HH[i] + T_OH[i];
    low = T_LW[i] + T_OW[i]; hiw = T_DW[i] - 1 + T_HW[i] + T_OW[i];
    mb = T_B[i]; mh = T_SH[i] + T_OH[i]; mw = T_SW[i] + T_OW[i];
    @(negedge clk); set_cfg(i); req_start = 1'b1;
    @(negedge clk); req_start = 1'b0;
    chk(pix_valid == 1'b1, "R3 valid after start", int'(pix_valid), 1);
    got = 0; cyc = 0; stalled = 0; ph = 0; pw = 0;
    while (got < T_N[i] && cyc < 500) begin
      pix_ready = ((cyc * 7 + i) % 3) != 0;
      if (got == 3) begin
        req_start = 1'b1; start_h = CW'(9); lo_w = CW'(5); step_w = SW'(3); start_chan = CHW'(1);
      end else req_start = 1'b0;
      #1;
      if (stalled) begin
        chk(int'(pix_h) == ph && int'(pix_w) == pw, "R9 hold h", int'(pix_h), ph);
      end
      chk(pix_valid == 1'b1, "R8 valid during walk", int'(pix_valid), 1);
      if (pix_ready) begin
        einb = (mh >= 0) && (mh < T_DH[i]) && (mw >= 0) && (mw < T_DW[i]);
        chk(int'(pix_batch) == mb, (got > 3) ? "R10 R5 batch" : "R5 batch", int'(pix_batch), mb);
        chk(int'(pix_h) == mh, "R2 R4 row", int'(pix_h), mh);
        chk(int'(pix_w) == mw, "R2 R4 column", int'(pix_w), mw);
        chk(int'(pix_chan) == T_CH[i], "R3 chan", int'(pix_chan), T_CH[i]);
        chk(pix_inb == einb, "R6 inb", int'(pix_inb), int'(einb));
        chk(pix_fill_nan == (!einb && T_NAN[i] != 0), "R7 fill", int'(pix_fill_nan),
            int'(!einb && T_NAN[i] != 0));
        got++;
        if (mw + T_TW[i] <= hiw) mw = mw + T_TW[i];
        else begin
          mw = low;
          if (mh + T_TH[i] <= hih) mh = mh + T_TH[i];
          else begin mh = loh; mb = (mb + 1) % 256; end
        end
        stalled = 0;
      end else begin
        stalled = 1; ph = int'(pix_h); pw = int'(pix_w);
      end
      cyc++;
      @(negedge clk);
    end
    req_start = 1'b0; pix_ready = 1'b0;
    #1;
    chk(req_done == 1'b1, "R8 done pulse", int'(req_done), 1);
    chk(pix_valid == 1'b0 && req_busy == 1'b0, "R8 idle after last", int'(pix_valid), 0);
    @(negedge clk); #1;
    chk(req_done == 1'b0, "R8 done one cycle", int'(req_done), 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int eh [6] = '{1, 2, 2, 2, 2, -1};
    int ew [6] = '{2, -1, 0, 1, 2, -1};
    int eb [6] = '{0, 0, 0, 0, 0, 1};
    repeat (3) @(negedge clk);
    #1;
    chk(req_busy == 0 && req_done == 0 && pix_valid == 0, "R1 reset idle",
        int'(req_busy) + int'(req_done) + int'(pix_valid), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NCFG; i++) run_cfg(i);

    // R5 literal wrap sequence of the padded window example
    @(negedge clk); set_cfg(1); req_start = 1'b1;
    @(negedge clk); req_start = 1'b0; pix_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk(int'(pix_batch) == eb[k] && int'(pix_h) == eh[k] && int'(pix_w) == ew[k],
          "R5 literal pixel", int'(pix_h) * 100 + int'(pix_w), eh[k] * 100 + ew[k]);
      @(negedge clk);
    end
    while (req_busy) @(negedge clk);
    pix_ready = 1'b0;
    @(negedge clk);

    // R11 zero-length request
    set_cfg(0); pix_count = '0; req_start = 1'b1;
    @(negedge clk); req_start = 1'b0; #1;
    chk(req_done == 1'b1 && pix_valid == 1'b0, "R11 zero count done", int'(req_done), 1);
    @(negedge clk); #1;
    chk(req_done == 1'b0 && req_busy == 1'b0, "R11 zero count idle", int'(req_done), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule